// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point numbers in the common single-precision layout and returns a correctly rounded single-precision sum. A caller places both operands and a rounding-mode code on the inputs and raises `start_i` for one cycle. One cycle later `done_o` pulses and `sum_o` holds the result. `sum_o` keeps that value until the next start.

Inside the block, each operand is expanded into a sign, a biased exponent and a 27-bit working mantissa. The working mantissa is the explicit leading one, the 23 fraction bits, and three low bits used for rounding. The operand with the smaller magnitude is shifted right by the exponent difference to line it up with the larger one. The two magnitudes are then added or subtracted, the result is renormalised, and it is rounded under one of four modes.

Normal numbers and exact zeros are handled. Infinities, NaNs, subnormal values and exponent overflow or underflow are not handled.

Top module: `sp_fadd`

## Requirements
- R1: Operand fields are sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. A non-zero exponent field implies a leading one above the fraction.
- R2: When both operand signs are equal, `sum_o` is the magnitude sum, rounded under the selected mode, and carries the shared sign.
- R3: When the signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger operand.
- R4: Bits of the smaller operand shifted below the working precision during alignment still affect rounding, in both addition and subtraction.
- R5: Rounding code 00 rounds to nearest, and an exact tie goes to the value with an even last fraction bit.
- R6: Rounding code 01 truncates toward zero. Code 10 rounds toward +infinity. Code 11 rounds toward -infinity.
- R7: A carry out of the magnitude sum raises the exponent by one. Cancellation in a subtraction shifts the mantissa left and lowers the exponent by the shift amount.
- R8: A result of exact zero is 0x00000000 under codes 00, 01 and 10, and 0x80000000 under code 11.
- R9: An operand whose exponent field is zero is treated as zero, whatever its fraction bits hold. The other operand then passes through unchanged.
- R10: `done_o` is high in exactly the cycle after a cycle in which `start_i` is high. `sum_o` changes only in such a cycle.
- R11: While reset is asserted, `sum_o` reads 0 and `done_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to add the presented operands |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| rmode_i | input | 2 | Rounding code: 00 nearest-even, 01 toward zero, 10 up, 11 down |
| sum_o | output | 32 | Registered rounded sum |
| done_o | output | 1 | High in the cycle the new sum is valid |

## Verification
The bench aims at the cases where the three extra mantissa bits matter:
- A tiny addend far below the last fraction bit. A design that drops the sticky information would round 1 + 2^-30 the same way under every mode, and would return 1.0 for 1 - 2^-30 under truncation.
- Exact ties. A design that always rounds half up would return an odd last bit where an even one is required.
- Equal-magnitude cancellation and near-cancellation. Wrong shift arithmetic would produce a misplaced exponent or the wrong sign of zero.

A behavioural model computes every sum with 65-bit exact arithmetic, so random vectors expose an alignment, normalisation or rounding slip as a mismatched bit pattern.

// File: rtl/sp_fadd.sv
module sp_fadd #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [EW+FW:0]   opa_i,
  input  logic [EW+FW:0]   opb_i,
  input  logic [1:0]       rmode_i,
  output logic [EW+FW:0]   sum_o,
  output logic             done_o
);
  localparam int TW  = EW + FW + 1;
  localparam int MW  = FW + 1;
  localparam int WW  = MW + 3;
  localparam int LZW = $clog2(WW + 1);
  localparam logic [WW-1:0] ONE   = 1;
  localparam logic [EW:0]   SHLIM = (EW+1)'(WW);

  function automatic logic [LZW-1:0] lead_zeros(input logic [WW-1:0] v);
    logic [LZW-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = WW - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n = n + 1'b1;
      end
    end
    return n;
  endfunction

  logic              sa, sb;
  logic [EW-1:0]     ea, eb;
  logic [WW-1:0]     ma, mb;

  assign sa = opa_i[TW-1];
  assign sb = opb_i[TW-1];
  assign ea = opa_i[TW-2:FW];
  assign eb = opb_i[TW-2:FW];
  assign ma = (ea == '0) ? '0 : {1'b1, opa_i[FW-1:0], 3'b000};
  assign mb = (eb == '0) ? '0 : {1'b1, opb_i[FW-1:0], 3'b000};

  logic signed [EW:0] ediff;
  logic               a_big;
  logic [EW:0]        shamt;
  logic               s_big;
  logic [EW-1:0]      e_big;
  logic [WW-1:0]      m_big, m_sml;

  assign ediff = $signed({1'b0, ea}) - $signed({1'b0, eb});
  assign a_big = (ediff > 0) || ((ediff == 0) && (ma >= mb));
  assign shamt = a_big ? ediff : -ediff;
  assign s_big = a_big ? sa : sb;
  assign e_big = a_big ? ea : eb;
  assign m_big = a_big ? ma : mb;
  assign m_sml = a_big ? mb : ma;

  logic [WW-1:0] shifted, m_al;
  logic          sticky;

  always_comb begin
    if (shamt >= SHLIM) begin
      shifted = '0;
      sticky  = |m_sml;
    end else begin
      shifted = m_sml >> shamt;
      sticky  = |(m_sml & ((ONE << shamt) - ONE));
    end
    m_al = {shifted[WW-1:1], shifted[0] | sticky};
  end

  logic [WW:0] raw;
  assign raw = (sa == sb) ? ({1'b0, m_big} + {1'b0, m_al})
                          : ({1'b0, m_big} - {1'b0, m_al});

  logic [LZW-1:0] lz;
  logic [WW-1:0]  m_n;
  logic [EW-1:0]  e_n;
  logic           is_zero;

  assign lz      = lead_zeros(raw[WW-1:0]);
  assign is_zero = (raw == '0);

  always_comb begin
    if (raw[WW]) begin
      m_n = {raw[WW:2], raw[1] | raw[0]};
      e_n = e_big + 1'b1;
    end else begin
      m_n = raw[WW-1:0] << lz;
      e_n = e_big - {{(EW-LZW){1'b0}}, lz};
    end
  end

  logic [MW-1:0] keep;
  logic          g_bit, rs_bits, inc;
  logic [MW:0]   rsum;
  logic [FW-1:0] frac;
  logic [EW-1:0] e_r;
  logic [TW-1:0] res;

  assign keep    = m_n[WW-1:3];
  assign g_bit   = m_n[2];
  assign rs_bits = |m_n[1:0];

  always_comb begin
    case (rmode_i)
      2'b00:   inc = g_bit & (rs_bits | keep[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~s_big & (g_bit | rs_bits);
      default: inc = s_big & (g_bit | rs_bits);
    endcase
  end

  assign rsum = {1'b0, keep} + {{MW{1'b0}}, inc};
  assign frac = rsum[MW] ? rsum[FW:1] : rsum[FW-1:0];
  assign e_r  = rsum[MW] ? e_n + 1'b1 : e_n;
  assign res  = is_zero ? {(rmode_i == 2'b11), {(TW-1){1'b0}}}
                        : {s_big, e_r, frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) sum_o <= res;
    end
  end
endmodule

// File: rtl/sp_fadd_chk.sv
module sp_fadd_chk #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [EW+FW:0]   opa_i,
  input logic [EW+FW:0]   opb_i,
  input logic [1:0]       rmode_i,
  input logic [EW+FW:0]   sum_o,
  input logic             done_o
);
  localparam int TW = EW + FW + 1;

  // R10
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  // R10
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(sum_o)));

  // R8
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && sum_o[TW-2:0] == '0) |-> (sum_o[TW-1] == ($past(rmode_i) == 2'b11)));

  // R9
  zero_operand_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && opb_i[TW-2:FW] == '0 && opa_i[TW-2:FW] != '0) |=> (sum_o == $past(opa_i)));

  // R3
  cancel_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && opa_i == {~opb_i[TW-1], opb_i[TW-2:0]}) |=> (sum_o[TW-2:0] == '0));
endmodule

bind sp_fadd sp_fadd_chk #(.EW(EW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
  .rmode_i(rmode_i), .sum_o(sum_o), .done_o(done_o)
);

// File: tb/sp_fadd_tb.sv
`timescale 1ns/1ps
module sp_fadd_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [1:0]  rmode_i = '0;
  logic [31:0] sum_o;
  logic        done_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sp_fadd dut_i (.clk(clk), .rst_n(rst_n), .start_i(start_i), .opa_i(opa_i),
                 .opb_i(opb_i), .rmode_i(rmode_i), .sum_o(sum_o), .done_o(done_o));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m);
    int ea, eb, eB, eS, d, p, eR;
    logic [64:0] fa, fb, big, sml, s, lower, half, one;
    logic [24:0] keep;
    logic sg, inc;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    fa = (ea == 0) ? 65'd0 : ({41'd0, 1'b1, a[22:0]} << 40);
    fb = (eb == 0) ? 65'd0 : ({41'd0, 1'b1, b[22:0]} << 40);
    if (ea > eb || (ea == eb && fa >= fb)) begin
      big = fa; sml = fb; eB = ea; eS = eb; sg = a[31];
    end else begin
      big = fb; sml = fa; eB = eb; eS = ea; sg = b[31];
    end
    d = eB - eS;
    if (sml != 0) begin
      if (d > 40) sml = 65'd1;
      else sml = sml >> d;
    end
    s = (a[31] == b[31]) ? big + sml : big - sml;
    if (s == 0) return {(m == 2'b11), 31'd0};
    p = 0;
    for (int i = 0; i < 65; i++) if (s[i]) p = i;
    one   = 65'd1;
    lower = s & ((one << (p - 23)) - one);
    half  = one << (p - 24);
    keep  = 25'(s >> (p - 23));
    case (m)
      2'b00:   inc = (lower > half) || (lower == half && keep[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = !sg && (lower != 0);
      default: inc = sg && (lower != 0);
    endcase
    keep = keep + 25'(inc);
    eR = eB + p - 63;
    if (keep[24]) begin keep = keep >> 1; eR++; end
    return {sg, 8'(eR), keep[22:0]};
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                       input logic [31:0] exp, input string tag);
    logic [31:0] held;
    @(negedge clk);
    opa_i = a; opb_i = b; rmode_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    opa_i = ~a; opb_i = ~b;
    check(done_o === 1'b1, {tag, " done pulse (R10)"}, {31'd0, done_o}, 32'd1);
    check(sum_o === exp, tag, sum_o, exp);
    held = sum_o;
    @(negedge clk);
    check(done_o === 1'b0 && sum_o === held, {tag, " hold (R10)"}, sum_o, held);
  endtask

  task automatic both(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                      input logic [31:0] exp, input string tag);
    check(model(a, b, m) === exp, {tag, " model"}, model(a, b, m), exp);
    apply(a, b, m, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sum_o === 32'd0 && done_o === 1'b0, "R11 reset state", sum_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    both(32'h3F800000, 32'h3F800000, 2'b00, 32'h40000000, "R2 R7 carry 1+1");
    both(32'h3FC00000, 32'hBF800000, 2'b00, 32'h3F000000, "R3 1.5-1");
    both(32'h3F800000, 32'hBFC00000, 2'b00, 32'hBF000000, "R3 sign of larger");
    both(32'h3F800000, 32'hBF800000, 2'b00, 32'h00000000, "R8 zero nearest");
    both(32'h3F800000, 32'hBF800000, 2'b01, 32'h00000000, "R8 zero trunc");
    both(32'h3F800000, 32'hBF800000, 2'b11, 32'h80000000, "R8 zero down");
    both(32'h40490FDB, 32'h00000000, 2'b00, 32'h40490FDB, "R9 plus zero");
    both(32'h00001234, 32'hC0490FDB, 2'b10, 32'hC0490FDB, "R1 R9 zero exponent");
    both(32'h3F800000, 32'h30800000, 2'b00, 32'h3F800000, "R4 R5 sticky nearest");
    both(32'h3F800000, 32'h30800000, 2'b10, 32'h3F800001, "R4 R6 sticky up");
    both(32'h3F800000, 32'h30800000, 2'b01, 32'h3F800000, "R4 R6 sticky trunc");
    both(32'hBF800000, 32'hB0800000, 2'b11, 32'hBF800001, "R4 R6 sticky down neg");
    both(32'h3F800000, 32'hB0800000, 2'b01, 32'h3F7FFFFF, "R4 R6 sub sticky trunc");
    both(32'h3F800000, 32'hB0800000, 2'b00, 32'h3F800000, "R4 R5 sub sticky nearest");
    both(32'h3F800000, 32'hB0800000, 2'b11, 32'h3F7FFFFF, "R4 R6 sub sticky down");
    both(32'h3F800000, 32'h33800000, 2'b00, 32'h3F800000, "R5 tie to even low");
    both(32'h3F800001, 32'h33800000, 2'b00, 32'h3F800002, "R5 tie to even high");
    both(32'h3F800000, 32'h33800000, 2'b10, 32'h3F800001, "R6 tie up");
    both(32'h3F800001, 32'hBF800000, 2'b00, 32'h34000000, "R7 cancellation");

    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, b;
      int ea, eb;
      ea = 60 + int'($urandom % 130);
      eb = ea + int'($urandom % 61) - 30;
      if (k % 5 == 0) eb = ea;
      a = {1'($urandom), 8'(ea), 23'($urandom)};
      b = {1'($urandom), 8'(eb), 23'($urandom)};
      apply(a, b, 2'(k), model(a, b, 2'(k)),
            (a[31] == b[31]) ? "R2 R5 R6 random same sign" : "R3 R5 R6 random mixed sign");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule